// File: doc/BRIEF.md
# Soft Power Button Delay Controller

This block turns a press of the power button into a power-down request that comes after a delay, so that software has time to react. A rising edge on the button input, which has already been debounced, loads a countdown with the programmed delay in milliseconds. A prescaler divides the system clock into one-millisecond ticks, and each tick decrements the count. When the count runs out, the block emits a single-cycle power-down pulse and returns to idle.

Software reaches the block through a small register port with write enable, address, write data and a combinational read path. The command register holds three write-one actions. Stop aborts a pending shutdown. Restart re-arms the full delay and can be repeated without limit. Force requests a power-down at once. None of these bits holds after the write. Reading the command register shows whether the countdown is stopped. A second register holds the delay value, which resets to 500 ms.

Top module: `pwrbtn_delay`

## Requirements
- R1: After reset the countdown is idle, `running_o` and `pwr_down_o` are 0, and the delay register (address 1) reads 500.
- R2: A 0-to-1 transition on `btn_i` while idle starts the countdown (`running_o` goes to 1 after that clock edge). Holding `btn_i` high does not start the countdown again.
- R3: The power-down pulse appears exactly `max(D,1) * TICKS_PER_MS` cycles after the starting edge, where D is the delay loaded at that edge. It lasts one cycle, and the countdown is then idle.
- R4: A button edge that arrives while the countdown runs is ignored and does not reload the count.
- R5: Writing address 0 with bit 5 set ends the countdown with no power-down pulse.
- R6: Writing address 0 with bit 6 set while the countdown runs reloads the full delay, and this can be repeated any number of times. While idle it has no effect.
- R7: Writing address 0 with bit 7 set produces a power-down pulse in the next cycle whatever the counter state, and it ends any running countdown.
- R8: Reading address 0 returns bit 5 = 1 when the countdown is stopped and 0 when it runs. All other bits read 0, including reserved bit 4 and the command bits 6 and 7, which clear themselves.
- R9: If bits 5 and 6 are written together, stop wins. A stop or restart written in the cycle of the final tick suppresses that expiry's pulse.
- R10: The delay register at address 1 is read/write. Its value is taken only when the countdown starts or restarts, so a change during a countdown does not alter the count in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_i | input | 1 | Debounced power button level, high = pressed |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 = command, 1 = delay) |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data for `addr` |
| running_o | output | 1 | Countdown in progress |
| pwr_down_o | output | 1 | One-cycle power-down request |

## Verification
Two events can land in the same clock edge: the final millisecond tick that would expire the count, and a software stop or restart command. The bench works out the exact cycle of the last tick from the delay and the tick period. It writes stop or restart at that edge and then checks that no pulse appears and that the countdown is idle or re-armed. The random phase also produces such collisions, together with force, button edges and delay writes. A cycle-counting model judges each cycle by the remaining cycles before expiry.

// File: rtl/pbd_pkg.sv
package pbd_pkg;
  localparam int CMD_ADDR   = 0;
  localparam int DLY_ADDR   = 1;
  localparam int BIT_STOP   = 5;
  localparam int BIT_RESTRT = 6;
  localparam int BIT_FORCE  = 7;
  localparam int BIT_RSVD   = 4;

  // Width of the prescaler counter for a given period
  function automatic int pre_width(input int ticks);
    return (ticks > 1) ? $clog2(ticks) : 1;
  endfunction

  // True when the count has reached its final millisecond
  function automatic logic is_last(input logic [31:0] cnt);
    return (cnt <= 32'd1);
  endfunction
endpackage

// File: rtl/pbd_edge.sv
module pbd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_i,
  output logic press_o
);
  logic btn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) btn_q <= 1'b0;
    else        btn_q <= btn_i;
  end

  assign press_o = btn_i & ~btn_q;

  AST_PRESS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    press_o |=> !press_o); // R2
endmodule

// File: rtl/pbd_prescaler.sv
module pbd_prescaler #(
  parameter int TICKS_PER_MS = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic clr_i,
  output logic tick_o
);
  import pbd_pkg::*;
  localparam int PW = pre_width(TICKS_PER_MS);
  localparam logic [PW-1:0] LAST = PW'(TICKS_PER_MS - 1);

  logic [PW-1:0] pre_q;

  generate
    if (TICKS_PER_MS > 1) begin : g_div
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                pre_q <= '0;
        else if (clr_i || !en_i)   pre_q <= '0;
        else if (pre_q == LAST)    pre_q <= '0;
        else                       pre_q <= pre_q + 1'b1;
      end
      assign tick_o = en_i && (pre_q == LAST);

      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R3
    end else begin : g_pass
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= '0;
      end
      assign tick_o = en_i;
    end
  endgenerate
endmodule

// File: rtl/pbd_countdown.sv
module pbd_countdown #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             press_i,
  input  logic             stop_i,
  input  logic             restart_i,
  input  logic             force_i,
  input  logic             tick_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             load_o,
  output logic             expire_o,
  output logic             running_o,
  output logic             pdn_o
);
  import pbd_pkg::*;

  logic [DLY_W-1:0] cnt_q;
  logic             run_q;
  logic             pdn_q;
  logic             rearm;
  logic             start;

  assign expire_o = run_q && tick_i && is_last(32'(cnt_q));
  assign rearm    = !stop_i && restart_i && run_q;
  assign start    = !stop_i && press_i && !run_q;
  assign load_o   = rearm || start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      pdn_q <= 1'b0;
    end else begin
      pdn_q <= 1'b0;
      if (stop_i)              run_q <= 1'b0;
      else if (rearm)          cnt_q <= delay_i;
      else if (expire_o) begin run_q <= 1'b0; pdn_q <= 1'b1; end
      else if (start)    begin run_q <= 1'b1; cnt_q <= delay_i; end
      else if (tick_i && run_q) cnt_q <= cnt_q - 1'b1;
      if (force_i) begin
        pdn_q <= 1'b1;
        run_q <= 1'b0;
      end
    end
  end

  assign running_o = run_q;
  assign pdn_o     = pdn_q;

  AST_EXPIRE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !stop_i && !restart_i) |=> (pdn_o && !running_o)); // R3
  AST_PRESS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && press_i && !stop_i && !restart_i && !force_i && !tick_i)
      |=> (running_o && $stable(cnt_q))); // R4
  AST_STOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !force_i) |=> (!running_o && !pdn_o)); // R5
  AST_RESTART_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_i && run_q && !stop_i && !force_i)
      |=> (running_o && !pdn_o && cnt_q == $past(delay_i))); // R6
  AST_FORCE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    force_i |=> (pdn_o && !running_o)); // R7
endmodule

// File: rtl/pbd_regs.sv
module pbd_regs #(
  parameter int ADDR_W    = 2,
  parameter int DATA_W    = 16,
  parameter int DLY_W     = 16,
  parameter int DLY_RESET = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              running_i,
  output logic [DATA_W-1:0] rdata,
  output logic              stop_o,
  output logic              restart_o,
  output logic              force_o,
  output logic [DLY_W-1:0]  delay_o
);
  import pbd_pkg::*;

  logic            cmd_wr;
  logic            dly_wr;
  logic [DLY_W-1:0] dly_q;

  assign cmd_wr    = wr_en && (addr == ADDR_W'(CMD_ADDR));
  assign dly_wr    = wr_en && (addr == ADDR_W'(DLY_ADDR));
  assign stop_o    = cmd_wr && wdata[BIT_STOP];
  assign restart_o = cmd_wr && wdata[BIT_RESTRT] && !wdata[BIT_STOP];
  assign force_o   = cmd_wr && wdata[BIT_FORCE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dly_q <= DLY_W'(DLY_RESET);
    else if (dly_wr) dly_q <= wdata[DLY_W-1:0];
  end
  assign delay_o = dly_q;

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(CMD_ADDR))      rdata[BIT_STOP] = !running_i;
    else if (addr == ADDR_W'(DLY_ADDR)) rdata = DATA_W'(dly_q);
  end

  AST_CMD_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(CMD_ADDR)) |-> (rdata[BIT_RSVD] == 1'b0 && rdata[BIT_FORCE] == 1'b0)); // R8
  AST_DLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dly_wr |=> (delay_o == $past(wdata[DLY_W-1:0]))); // R10
endmodule

// File: rtl/pwrbtn_delay.sv
module pwrbtn_delay #(
  parameter int TICKS_PER_MS = 50000,
  parameter int ADDR_W       = 2,
  parameter int DATA_W       = 16,
  parameter int DLY_W        = 16,
  parameter int DLY_RESET    = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              btn_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              running_o,
  output logic              pwr_down_o
);
  logic             press;
  logic             stop_cmd;
  logic             restart_cmd;
  logic             force_cmd;
  logic             tick;
  logic             load;
  logic             expire;
  logic [DLY_W-1:0] delay;

  pbd_edge u_edge (
    .clk(clk), .rst_n(rst_n), .btn_i(btn_i), .press_o(press)
  );

  pbd_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DLY_W(DLY_W), .DLY_RESET(DLY_RESET)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .running_i(running_o), .rdata(rdata), .stop_o(stop_cmd),
    .restart_o(restart_cmd), .force_o(force_cmd), .delay_o(delay)
  );

  pbd_prescaler #(.TICKS_PER_MS(TICKS_PER_MS)) u_pre (
    .clk(clk), .rst_n(rst_n), .en_i(running_o), .clr_i(load), .tick_o(tick)
  );

  pbd_countdown #(.DLY_W(DLY_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .press_i(press), .stop_i(stop_cmd),
    .restart_i(restart_cmd), .force_i(force_cmd), .tick_i(tick),
    .delay_i(delay), .load_o(load), .expire_o(expire),
    .running_o(running_o), .pdn_o(pwr_down_o)
  );

  AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_o && !force_cmd) |=> !pwr_down_o); // R3
  AST_TICK_WHEN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> running_o); // R3
endmodule

// File: tb/pwrbtn_delay_test.sv
`timescale 1ns/1ps
module pwrbtn_delay_test;
  localparam int TPM = 3;
  localparam int DRST = 500;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        btn_i = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        running_o;
  logic        pwr_down_o;

  int errors = 0;
  int checks = 0;
  int pulses = 0;
  string cur = "R1";

  // reference model state
  logic        m_run, m_pdn, m_btn;
  int          m_rem;
  logic [15:0] m_dly;

  pwrbtn_delay #(.TICKS_PER_MS(TPM)) uut (
    .clk(clk), .rst_n(rst_n), .btn_i(btn_i), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .running_o(running_o), .pwr_down_o(pwr_down_o)
  );

  always #2 clk = ~clk;

  function automatic int span(input logic [15:0] d);
    return ((d == 16'd0) ? 1 : int'(d)) * TPM;
  endfunction

  function automatic logic [15:0] exp_rd(input logic [1:0] a, input logic run, input logic [15:0] d);
    if (a == 2'd0) return run ? 16'h0000 : 16'h0020;
    if (a == 2'd1) return d;
    return 16'h0000;
  endfunction

  always @(posedge clk) begin
    logic press, cw, s, r, f, expire;
    if (!rst_n) begin
      m_run = 0; m_pdn = 0; m_btn = 0; m_rem = 0; m_dly = 16'(DRST);
    end else begin
      press = btn_i && !m_btn;
      m_btn = btn_i;
      cw = wr_en && addr == 2'd0;
      s = cw && wdata[5]; r = cw && wdata[6]; f = cw && wdata[7];
      expire = 0; m_pdn = 0;
      if (m_run) begin
        if (m_rem == 1) expire = 1; else m_rem = m_rem - 1;
      end
      if (s) m_run = 0;
      else if (r && m_run) m_rem = span(m_dly);
      else if (expire) begin m_run = 0; m_pdn = 1; end
      else if (press && !m_run) begin m_run = 1; m_rem = span(m_dly); end
      if (f) begin m_pdn = 1; m_run = 0; end
      if (wr_en && addr == 2'd1) m_dly = wdata;
    end
  end

  task automatic check(input string tag, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (pwr_down_o) pulses++;
      check(cur, "pwr_down_o", int'(pwr_down_o), int'(m_pdn));
      check(cur, "running_o", int'(running_o), int'(m_run));
      check(cur, "rdata", int'(rdata), int'(exp_rd(addr, m_run, m_dly)));
    end
  end

  task automatic cyc(input logic b, input logic w, input logic [1:0] a, input logic [15:0] d);
    btn_i = b; wr_en = w; addr = a; wdata = d;
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(btn_i, 1'b0, 2'(i % 2), 16'h0);
  endtask

  task automatic press_btn();
    cyc(1'b1, 1'b0, 2'd0, 16'h0);
    cyc(1'b0, 1'b0, 2'd0, 16'h0);
  endtask

  task automatic cmd(input logic [15:0] bits);
    cyc(btn_i, 1'b1, 2'd0, bits);
  endtask

  task automatic set_dly(input logic [15:0] v);
    cyc(btn_i, 1'b1, 2'd1, v);
  endtask

  task automatic expect_pulses(input string tag, input int base, input int n);
    check(tag, "pulse count", pulses - base, n);
  endtask

  initial begin
    int p;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cur = "R1";
    #1; check("R1", "running after reset", int'(running_o), 0);
    check("R1", "pulse after reset", int'(pwr_down_o), 0);
    addr = 2'd1; #1; check("R1", "delay reset value", int'(rdata), DRST);
    @(posedge clk); #1;
    idle(2);

    cur = "R10"; set_dly(16'd4); idle(1);
    cur = "R2"; p = pulses;
    cyc(1'b1, 1'b0, 2'd0, 16'h0);           // held high across expiry
    idle(4 * TPM + 10);
    cur = "R3"; expect_pulses("R3", p, 1);
    btn_i = 1'b0; idle(2);

    cur = "R4"; p = pulses;
    press_btn(); idle(4); press_btn(); idle(4 * TPM + 6);
    expect_pulses("R4", p, 1);

    cur = "R5"; p = pulses;
    press_btn(); idle(4); cmd(16'h0020); idle(4 * TPM + 6);
    expect_pulses("R5", p, 0);

    cur = "R6"; p = pulses;
    press_btn();
    for (int i = 0; i < 5; i++) begin idle(8); cmd(16'h0040); end
    check("R6", "running after restarts", int'(running_o), 1);
    idle(4 * TPM + 6);
    expect_pulses("R6", p, 1);
    cmd(16'h0040); idle(1);
    check("R6", "restart while idle", int'(running_o), 0);

    cur = "R7"; p = pulses;
    cmd(16'h0080); idle(2);
    expect_pulses("R7", p, 1);
    press_btn(); idle(3); cmd(16'h0080); idle(4 * TPM + 6);
    expect_pulses("R7", p, 2);

    cur = "R8"; cmd(16'h00FF); addr = 2'd0; #1;
    check("R8", "cmd readback stopped", int'(rdata), 16'h0020);
    idle(2);

    cur = "R9"; p = pulses;
    press_btn(); idle(2); cmd(16'h0060); idle(4 * TPM + 4);
    expect_pulses("R9", p, 0);
    // restart exactly on the final tick: press edge k, idle to k+N-1, write at k+N
    cyc(1'b1, 1'b0, 2'd0, 16'h0); btn_i = 1'b0;
    idle(4 * TPM - 1); cmd(16'h0040);
    check("R9", "re-armed on final tick", int'(running_o), 1);
    check("R9", "no pulse on final tick", int'(pwr_down_o), 0);
    idle(4 * TPM + 4);
    expect_pulses("R9", p, 1);
    cyc(1'b1, 1'b0, 2'd0, 16'h0); btn_i = 1'b0;
    idle(4 * TPM - 1); cmd(16'h0020); idle(4 * TPM);
    expect_pulses("R9", p, 1);

    cur = "R10"; p = pulses;
    press_btn(); idle(2); set_dly(16'd1); idle(4 * TPM + 4);
    expect_pulses("R10", p, 1);
    set_dly(16'd0); press_btn(); idle(TPM + 4);
    expect_pulses("R10", p, 2);

    cur = "R1"; rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
    cur = "R3"; p = pulses;
    press_btn(); idle(DRST * TPM + 4);
    expect_pulses("R3", p, 1);

    cur = "R9";
    void'($urandom(32'd1234));
    for (int i = 0; i < 6000; i++) begin
      int k;
      k = $urandom_range(0, 99);
      if (k < 4)       cyc(~btn_i, 1'b1, 2'd0, 16'(($urandom_range(0, 7)) << 5));
      else if (k < 7)  cyc(btn_i, 1'b1, 2'd1, 16'($urandom_range(0, 6)));
      else if (k < 15) cyc(~btn_i, 1'b0, 2'($urandom_range(0, 3)), 16'h0);
      else             cyc(btn_i, 1'b0, 2'($urandom_range(0, 3)), 16'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL all watchdog actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule